// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of an external parallel NOR flash and turns one request into the whole bus conversation. A request carries an operation code, an address and a data word. The block then writes the unlock preamble that goes with that operation. Each write is a clock-counted chip-enable, write-enable and output-enable sequence. After the last write, the block reads one fixed address over and over until the device reports that it has finished.

The device shows that it is busy by inverting status bit 6 on every read. It shows that it is finished when two reads in a row return the same bit 6. If that does not happen within a per-operation limit, the block gives up. Each request ends with a one-cycle `done` or `timeout` pulse. All strobe widths are nanosecond parameters, converted to cycles from the clock frequency parameter and rounded up. The timeout limits are microsecond parameters, and program and erase each have their own.

Top module: `nfs_seq`

## Requirements
- R1: Operation code 2'b01 (word program) produces exactly four writes, as (address, low data byte): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, request data).
- R2: Operation code 2'b10 (sector erase) produces exactly six writes: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), then (request address, 0x30). The upper data byte is zero on every command write.
- R3: Operation code 2'b11 (chip erase) produces the same first five writes as R2, then (0x5555, 0x10).
- R4: During each write, chip-enable is low and output-enable is high. Write-enable stays low for at least the longest of the pulse width, data setup and address hold: 10 cycles at 50 MHz. Address and data are driven and stable for the whole low phase. The address settles at least one cycle before write-enable falls. Write-enable stays high for at least 10 cycles between writes.
- R5: Polling reads use the request address and never drive the data bus. Output-enable stays low for at least the access time (6 cycles at 50 MHz). It stays high for at least 150 ns (8 cycles) between successive reads.
- R6: `done` is raised after the first read whose bit 6 equals bit 6 of the read just before it, and no further read is started.
- R7: If completion is not seen, `timeout` is raised instead. It is raised at least the operation's limit after polling starts and at most one poll period later. The program limit is PROG_TIMEOUT_US and the erase limit is ERASE_TIMEOUT_US, so an erase may poll longer than a program could.
- R8: `done` and `timeout` are single-cycle pulses and never occur together. `busy` is low in the cycle in which either pulse is high.
- R9: A request is accepted only while `busy` is low and the code is not 2'b00. A request made while busy does not change the operation in progress, and code 2'b00 starts nothing.
- R10: While reset is held, and in the cycle after it is applied mid-operation, `busy` is low, chip-enable, write-enable and output-enable are high, and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 01 program, 10 sector erase, 11 chip erase, 00 none |
| req_addr | input | ADDR_W | Target word address, sector address, or polling address |
| req_data | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle timeout pulse |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_o | output | DATA_W | Flash data out |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | DATA_W | Flash data in |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Each of the three operations is run against a flash model that flips bit 6 for a chosen number of reads. The cases are zero, odd and even busy counts. The even and odd cases differ in the number of reads needed, because a matching pair can only occur after the toggling stops. A long erase that polls past the program limit and still completes shows that the two limits are separate. Endless toggling on a program and on a chip erase shows that each times out at its own limit. Directed cases cover a second request during an operation, the empty operation code, and a reset in the middle of a write sequence.

// File: rtl/nfs_pkg.sv
// Shared types and constants for the NOR flash sequencer.
// Assumes unlock addresses fit in 15 bits and the address bus is wider.
package nfs_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SERASE = 2'd2,
        OP_CERASE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_WSET, PH_WLO, PH_WHI, PH_RLO, PH_ROH
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_WRITE, SQ_POLL
    } seq_e;

    localparam logic [14:0] UNLOCK_HI  = 15'h5555;
    localparam logic [14:0] UNLOCK_LO  = 15'h2AAA;
    localparam logic [7:0]  CODE_PRE1  = 8'hAA;
    localparam logic [7:0]  CODE_PRE2  = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam int          STAT_BIT   = 6;

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input longint ns, input longint clk_hz);
        longint c;
        c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/nfs_cmd_gen.sv
// Command word generator: maps (operation, step) to the address and data
// for that write, and marks the final write of the sequence.
// Assumes step stays within the sequence length of the operation.
module nfs_cmd_gen
    import nfs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              last
);

    logic       use_hi;
    logic       use_tgt_a;
    logic       use_tgt_d;
    logic [7:0] code;

    // Select the unlock address, command code and target substitution per step.
    always_comb begin
        use_hi    = 1'b1;
        use_tgt_a = 1'b0;
        use_tgt_d = 1'b0;
        code      = CODE_PRE1;
        last      = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0:    begin use_hi = 1'b1; code = CODE_PRE1; end
                3'd1:    begin use_hi = 1'b0; code = CODE_PRE2; end
                3'd2:    begin use_hi = 1'b1; code = CODE_PROG; end
                default: begin use_tgt_a = 1'b1; use_tgt_d = 1'b1; last = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0:    begin use_hi = 1'b1; code = CODE_PRE1;  end
                3'd1:    begin use_hi = 1'b0; code = CODE_PRE2;  end
                3'd2:    begin use_hi = 1'b1; code = CODE_ERASE; end
                3'd3:    begin use_hi = 1'b1; code = CODE_PRE1;  end
                3'd4:    begin use_hi = 1'b0; code = CODE_PRE2;  end
                default: begin
                    last      = 1'b1;
                    use_tgt_a = (op == OP_SERASE);
                    code      = (op == OP_SERASE) ? CODE_SECT : CODE_CHIP;
                end
            endcase
        end
    end

    // Drive the resolved address and data words.
    always_comb begin
        bus_addr = use_tgt_a ? tgt_addr
                             : ADDR_W'(use_hi ? UNLOCK_HI : UNLOCK_LO);
        bus_data = use_tgt_d ? tgt_data : DATA_W'(code);
    end

endmodule

// File: rtl/nfs_strobe.sv
// Bus phase timer: one write cycle (setup, write-enable low, write-enable
// high) or one read cycle (output-enable low, output-enable high), each
// phase lasting a fixed number of clocks. Starts only from idle.
module nfs_strobe
    import nfs_pkg::*;
#(
    parameter int SET_C = 1,
    parameter int WLO_C = 10,
    parameter int WHI_C = 10,
    parameter int RLO_C = 6,
    parameter int ROH_C = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_go,
    output logic we_n,
    output logic oe_n,
    output logic drive,
    output logic idle,
    output logic wr_end,
    output logic rd_smp
);

    localparam int M1   = (SET_C > WLO_C) ? SET_C : WLO_C;
    localparam int M2   = (WHI_C > RLO_C) ? WHI_C : RLO_C;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXC = (M3 > ROH_C) ? M3 : ROH_C;
    localparam int CW   = $clog2(MAXC + 1);

    phase_e        ph;
    logic [CW-1:0] cnt;

    // Phase sequencing with a down-counter per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (wr_go) begin
                        ph  <= PH_WSET;
                        cnt <= CW'(SET_C - 1);
                    end else if (rd_go) begin
                        ph  <= PH_RLO;
                        cnt <= CW'(RLO_C - 1);
                    end
                end
                PH_WSET: if (cnt == '0) begin ph <= PH_WLO; cnt <= CW'(WLO_C - 1); end
                         else cnt <= cnt - 1'b1;
                PH_WLO:  if (cnt == '0) begin ph <= PH_WHI; cnt <= CW'(WHI_C - 1); end
                         else cnt <= cnt - 1'b1;
                PH_WHI:  if (cnt == '0) ph <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                PH_RLO:  if (cnt == '0) begin ph <= PH_ROH; cnt <= CW'(ROH_C - 1); end
                         else cnt <= cnt - 1'b1;
                PH_ROH:  if (cnt == '0) ph <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Strobe and event decode from the current phase.
    always_comb begin
        we_n   = (ph != PH_WLO);
        oe_n   = (ph != PH_RLO);
        drive  = (ph == PH_WSET) || (ph == PH_WLO) || (ph == PH_WHI);
        idle   = (ph == PH_IDLE);
        wr_end = (ph == PH_WHI) && (cnt == '0);
        rd_smp = (ph == PH_RLO) && (cnt == '0);
    end

endmodule

// File: rtl/nfs_tmo.sv
// Saturating completion timer with one limit per operation class.
// Counts while not cleared; expired once the selected limit is reached.
module nfs_tmo #(
    parameter int     TW        = 12,
    parameter longint PROG_LIM  = 1000,
    parameter longint ERASE_LIM = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic is_erase,
    output logic expired
);

    localparam logic [TW-1:0] PL = TW'(PROG_LIM);
    localparam logic [TW-1:0] EL = TW'(ERASE_LIM);

    logic [TW-1:0] cnt;

    // Elapsed-cycle counter, held at all-ones once it gets there.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end

    // Compare against the limit of the running operation.
    always_comb expired = (cnt >= (is_erase ? EL : PL));

endmodule

// File: rtl/nfs_seq.sv
// NOR flash program/erase sequencer top. Accepts one request while idle,
// writes its unlock preamble and command, then polls the request address
// until status bit 6 repeats on two reads, or the operation limit passes.
// Assumes the flash data bus is at least 7 bits and the address at least 15.
module nfs_seq
    import nfs_pkg::*;
#(
    parameter int ADDR_W           = 18,
    parameter int DATA_W           = 16,
    parameter int CLK_HZ           = 50_000_000,
    parameter int TAS_NS           = 10,
    parameter int TWP_NS           = 200,
    parameter int TWPH_NS          = 200,
    parameter int TAH_NS           = 100,
    parameter int TDS_NS           = 100,
    parameter int TACC_NS          = 120,
    parameter int TOEHP_NS         = 150,
    parameter int PROG_TIMEOUT_US  = 1000,
    parameter int ERASE_TIMEOUT_US = 12_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_i,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int SET_C  = ns_to_cycles(TAS_NS, CLK_HZ);
    localparam int WP_C   = ns_to_cycles(TWP_NS, CLK_HZ);
    localparam int DS_C   = ns_to_cycles(TDS_NS, CLK_HZ);
    localparam int AH_C   = ns_to_cycles(TAH_NS, CLK_HZ);
    localparam int WLO_T  = (WP_C > DS_C) ? WP_C : DS_C;
    localparam int WLO_C  = (WLO_T > AH_C) ? WLO_T : AH_C;
    localparam int WHI_C  = ns_to_cycles(TWPH_NS, CLK_HZ);
    localparam int RLO_C  = ns_to_cycles(TACC_NS, CLK_HZ);
    localparam int ROH_C  = ns_to_cycles(TOEHP_NS, CLK_HZ);
    localparam longint CYC_PER_US = longint'(CLK_HZ) / 64'd1_000_000;
    localparam longint PROG_LIM   = longint'(PROG_TIMEOUT_US) * CYC_PER_US;
    localparam longint ERASE_LIM  = longint'(ERASE_TIMEOUT_US) * CYC_PER_US;
    localparam longint MAX_LIM    = (PROG_LIM > ERASE_LIM) ? PROG_LIM : ERASE_LIM;
    localparam int     TW         = $clog2(MAX_LIM + 1) + 1;

    seq_e              state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        step;
    logic              first_q;
    logic              b6_q;

    logic              wr_go, rd_go;
    logic              s_we_n, s_oe_n, s_drive, s_idle, s_wr_end, s_rd_smp;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic              tmo_exp;
    logic              stat_b6;
    logic              dq_unused;

    assign stat_b6   = fl_dq_i[STAT_BIT];
    assign dq_unused = ^{fl_dq_i[DATA_W-1:STAT_BIT+1], fl_dq_i[STAT_BIT-1:0]};

    nfs_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .op       (op_q),
        .step     (step),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .bus_addr (cmd_addr),
        .bus_data (cmd_data),
        .last     (cmd_last)
    );

    nfs_strobe #(
        .SET_C(SET_C), .WLO_C(WLO_C), .WHI_C(WHI_C),
        .RLO_C(RLO_C), .ROH_C(ROH_C)
    ) u_strb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .we_n   (s_we_n),
        .oe_n   (s_oe_n),
        .drive  (s_drive),
        .idle   (s_idle),
        .wr_end (s_wr_end),
        .rd_smp (s_rd_smp)
    );

    nfs_tmo #(.TW(TW), .PROG_LIM(PROG_LIM), .ERASE_LIM(ERASE_LIM)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state != SQ_POLL),
        .is_erase (op_q != OP_PROG),
        .expired  (tmo_exp)
    );

    // Request capture, write stepping and completion polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            step    <= '0;
            first_q <= 1'b1;
            b6_q    <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_valid && (op_e'(req_op) != OP_NONE)) begin
                        op_q   <= op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        step   <= '0;
                        state  <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (s_wr_end) begin
                        if (cmd_last) begin
                            state   <= SQ_POLL;
                            first_q <= 1'b1;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                SQ_POLL: begin
                    if (s_rd_smp) begin
                        if (!first_q && (stat_b6 == b6_q)) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end else if (tmo_exp) begin
                            timeout <= 1'b1;
                            state   <= SQ_IDLE;
                        end else begin
                            b6_q    <= stat_b6;
                            first_q <= 1'b0;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Cycle launch requests toward the phase timer.
    always_comb begin
        wr_go = (state == SQ_WRITE) && s_idle;
        rd_go = (state == SQ_POLL) && s_idle;
    end

    // Flash pin drive: command words while writing, fixed address while polling.
    always_comb begin
        busy     = (state != SQ_IDLE);
        fl_addr  = (state == SQ_POLL) ? addr_q : cmd_addr;
        fl_dq_o  = cmd_data;
        fl_dq_oe = s_drive;
        fl_we_n  = s_we_n;
        fl_oe_n  = s_oe_n;
        fl_ce_n  = (state == SQ_IDLE) && s_idle;
    end

endmodule

// File: rtl/nfs_seq_chk.sv
// Protocol checker for nfs_seq, attached by bind.
module nfs_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_dq_o,
    input logic              fl_dq_oe,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n
);

    a_r4_write_controls: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dq_oe));

    a_r4_bus_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

    a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && fl_we_n && !fl_ce_n));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    a_r8_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy);

    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_op != 2'b00)) |=> busy);

    a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && (req_op != 2'b00))) |=> !busy);

endmodule

bind nfs_seq nfs_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nfs_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .fl_addr   (fl_addr),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/test_nfs_seq.sv
// Bench for nfs_seq with a behavioural flash model that toggles bit 6.
module test_nfs_seq;

    localparam int WLO  = 10;
    localparam int WHI  = 10;
    localparam int RLO  = 6;
    localparam int ROH  = 8;
    localparam int PLIM = 20 * 50;
    localparam int ELIM = 60 * 50;
    localparam int NVEC = 7;

    // {op[1:0], addr[17:0], data[15:0], busy_reads[12:0], expect_timeout}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd1, 18'h12345, 16'hBEEF, 13'd3,    1'b0},
        {2'd1, 18'h00001, 16'h0000, 13'd0,    1'b0},
        {2'd2, 18'h1F000, 16'h0000, 13'd6,    1'b0},
        {2'd3, 18'h00000, 16'h0000, 13'd4,    1'b0},
        {2'd2, 18'h03000, 16'h0000, 13'd150,  1'b0},
        {2'd1, 18'h2ABCD, 16'h1234, 13'd4000, 1'b1},
        {2'd3, 18'h00010, 16'h0000, 13'd4000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [17:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        busy, done, timeout;
    logic [17:0] fl_addr;
    logic [15:0] fl_dq_o;
    logic        fl_dq_oe;
    logic [15:0] fl_dq_i = 16'h0000;
    logic        fl_ce_n, fl_we_n, fl_oe_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Bench-owned configuration read by the model.
    int          cfg_busy = 0;
    logic [17:0] cfg_paddr = '0;

    // Model-owned state.
    longint      cyc = 0;
    logic [17:0] m_prev_addr = '0;
    int          m_addr_age = 0;
    logic        m_prev_ce = 1'b1, m_prev_we = 1'b1, m_prev_oe = 1'b1;
    logic        m_prev_done = 1'b0, m_prev_tmo = 1'b0;
    int          m_op_wr = 0, m_op_rd = 0, m_busy_left = 0;
    bit          m_tog = 0;
    int          m_wlow = 0, m_whigh = 1000, m_olow = 0, m_ohigh = 1000;
    logic [17:0] m_cap_a = '0;
    logic [15:0] m_cap_d = '0;
    logic [17:0] m_wa [8];
    logic [15:0] m_wd [8];
    longint      m_last_wr = 0;
    int          r4_err = 0, r5_err = 0, r8_err = 0;
    int          done_cnt = 0, tmo_cnt = 0, ce_falls = 0;
    longint      tmo_cyc = 0;

    always #10 clk = ~clk;

    nfs_seq #(
        .PROG_TIMEOUT_US  (20),
        .ERASE_TIMEOUT_US (60)
    ) i_nfs_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .busy      (busy),
        .done      (done),
        .timeout   (timeout),
        .fl_addr   (fl_addr),
        .fl_dq_o   (fl_dq_o),
        .fl_dq_oe  (fl_dq_oe),
        .fl_dq_i   (fl_dq_i),
        .fl_ce_n   (fl_ce_n),
        .fl_we_n   (fl_we_n),
        .fl_oe_n   (fl_oe_n)
    );

    // Flash model and bus timing monitor, sampled on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (fl_addr !== m_prev_addr) m_addr_age = 0; else m_addr_age++;
        m_prev_addr = fl_addr;
        if (fl_ce_n == 1'b0 && m_prev_ce == 1'b1) begin
            ce_falls++;
            m_op_wr = 0; m_op_rd = 0; m_busy_left = cfg_busy; m_tog = 0;
            m_whigh = 1000; m_ohigh = 1000;
        end
        if (!fl_we_n) begin
            if (m_prev_we) begin
                if (m_addr_age < 1) r4_err++;
                if (m_op_wr > 0 && m_whigh < WHI) r4_err++;
                m_cap_a = fl_addr; m_cap_d = fl_dq_o; m_wlow = 0;
            end
            m_wlow++;
            if (fl_oe_n !== 1'b1 || fl_ce_n !== 1'b0 || fl_dq_oe !== 1'b1 ||
                fl_addr !== m_cap_a || fl_dq_o !== m_cap_d) r4_err++;
        end else begin
            if (!m_prev_we) begin
                if (m_wlow < WLO) r4_err++;
                if (m_op_wr < 8) begin m_wa[m_op_wr] = m_cap_a; m_wd[m_op_wr] = m_cap_d; end
                m_op_wr++;
                m_last_wr = cyc;
                m_whigh = 0;
            end
            m_whigh++;
        end
        if (!fl_oe_n) begin
            if (m_prev_oe) begin
                if (m_op_rd > 0 && m_ohigh < ROH) r5_err++;
                if (fl_addr !== cfg_paddr) r5_err++;
                m_op_rd++;
                if (m_busy_left > 0) begin
                    fl_dq_i = m_tog ? 16'h1F40 : 16'h1F00;
                    m_tog = !m_tog;
                    m_busy_left--;
                end else begin
                    fl_dq_i = 16'h1F40;
                end
                m_olow = 0;
            end
            m_olow++;
            if (fl_dq_oe !== 1'b0 || fl_we_n !== 1'b1) r5_err++;
        end else begin
            if (!m_prev_oe) begin
                if (m_olow < RLO) r5_err++;
                m_ohigh = 0;
            end
            m_ohigh++;
        end
        if (done) begin
            if (m_prev_done || busy) r8_err++;
            done_cnt++;
        end
        if (timeout) begin
            if (m_prev_tmo || busy || done) r8_err++;
            tmo_cnt++;
            tmo_cyc = cyc;
        end
        m_prev_ce = fl_ce_n; m_prev_we = fl_we_n; m_prev_oe = fl_oe_n;
        m_prev_done = done; m_prev_tmo = timeout;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Expected (address, data) of write k for an operation.
    function automatic logic [33:0] exp_wr(input logic [1:0] op, input int k,
                                           input logic [17:0] a, input logic [15:0] d);
        logic [17:0] ea;
        logic [15:0] ed;
        ea = 18'h05555; ed = 16'h00AA;
        case (k)
            0: begin ea = 18'h05555; ed = 16'h00AA; end
            1: begin ea = 18'h02AAA; ed = 16'h0055; end
            2: begin ea = 18'h05555; ed = (op == 2'd1) ? 16'h00A0 : 16'h0080; end
            3: if (op == 2'd1) begin ea = a; ed = d; end
               else begin ea = 18'h05555; ed = 16'h00AA; end
            4: begin ea = 18'h02AAA; ed = 16'h0055; end
            default: if (op == 2'd2) begin ea = a; ed = 16'h0030; end
                     else begin ea = 18'h05555; ed = 16'h0010; end
        endcase
        return {ea, ed};
    endfunction

    // Reads needed when the status toggles for b reads, starting low, then stays high.
    function automatic int exp_reads(input int b);
        int prev;
        int v;
        prev = 0;
        for (int k = 0; k < b + 4; k++) begin
            v = (k < b) ? (k % 2) : 1;
            if (k > 0 && v == prev) return k + 1;
            prev = v;
        end
        return -1;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
    endtask

    task automatic wait_end(input int d0, input int t0);
        while (done_cnt == d0 && tmo_cnt == t0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_writes(input logic [1:0] op, input logic [17:0] a,
                                input logic [15:0] d, input string tag);
        int nw;
        logic [33:0] e;
        nw = (op == 2'd1) ? 4 : 6;
        check(m_op_wr == nw, tag, "write count", m_op_wr, nw);
        for (int k = 0; k < nw && k < 8; k++) begin
            e = exp_wr(op, k, a, d);
            check({m_wa[k], m_wd[k]} == e, tag, $sformatf("write %0d addr/data", k),
                  {m_wa[k], m_wd[k]}, e);
        end
    endtask

    task automatic run_vec(input logic [49:0] v);
        logic [1:0]  op;
        logic [17:0] a;
        logic [15:0] d;
        int          b;
        bit          etmo;
        int          d0, t0, e4, e5, e8, lim;
        longint      dt;
        string       tag;
        op = v[49:48]; a = v[47:30]; d = v[29:14]; b = int'(v[13:1]); etmo = v[0];
        tag = (op == 2'd1) ? "R1" : (op == 2'd2) ? "R2" : "R3";
        cfg_busy = b; cfg_paddr = a;
        d0 = done_cnt; t0 = tmo_cnt; e4 = r4_err; e5 = r5_err; e8 = r8_err;
        issue(op, a, d);
        wait_end(d0, t0);
        check_writes(op, a, d, tag);
        if (!etmo) begin
            check(done_cnt == d0 + 1 && tmo_cnt == t0, "R6", "done without timeout",
                  done_cnt - d0, 1);
            check(m_op_rd == exp_reads(b), "R6", "poll read count", m_op_rd, exp_reads(b));
            if (b == 150)
                check(tmo_cnt == t0, "R7", "erase polls past program limit", tmo_cnt - t0, 0);
        end else begin
            lim = (op == 2'd1) ? PLIM : ELIM;
            dt = tmo_cyc - m_last_wr;
            check(tmo_cnt == t0 + 1 && done_cnt == d0, "R7", "timeout without done",
                  tmo_cnt - t0, 1);
            check(dt >= lim && dt <= lim + 40, "R7", "timeout window", dt, lim);
        end
        check(r4_err == e4, "R4", "write strobe timing violations", r4_err - e4, 0);
        check(r5_err == e5, "R5", "poll read timing violations", r5_err - e5, 0);
        check(r8_err == e8, "R8", "pulse violations", r8_err - e8, 0);
        check(busy == 1'b0, "R8", "busy after end", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int d0, t0, f0;
        // R10: state held in reset.
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10", "busy in reset", busy, 0);
        check({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R10", "strobes in reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        check(fl_dq_oe == 1'b0, "R10", "bus drive in reset", fl_dq_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R9: code 00 starts nothing.
        f0 = ce_falls;
        issue(2'b00, 18'h00123, 16'h5555);
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && ce_falls == f0, "R9", "empty op code activity",
              ce_falls - f0, 0);

        // R9: request during an operation is ignored.
        cfg_busy = 2; cfg_paddr = 18'h0A0A0;
        d0 = done_cnt; t0 = tmo_cnt;
        issue(2'b01, 18'h0A0A0, 16'hC3C3);
        repeat (30) @(negedge clk);
        issue(2'b11, 18'h00000, 16'h0000);
        wait_end(d0, t0);
        check_writes(2'b01, 18'h0A0A0, 16'hC3C3, "R9");
        check(done_cnt == d0 + 1, "R9", "single completion", done_cnt - d0, 1);

        // R10: reset in the middle of a write sequence.
        cfg_busy = 0; cfg_paddr = 18'h1F000;
        issue(2'b10, 18'h1F000, 16'h0000);
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R10", "busy after mid-op reset", busy, 0);
        check({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R10", "strobes after mid-op reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        check(fl_dq_oe == 1'b0, "R10", "bus drive after mid-op reset", fl_dq_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_vec({2'd1, 18'h00777, 16'h0F0F, 13'd1, 1'b0});

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule